// File: doc/BRIEF.md
# Cascaded Multirate Sinc Decimator

This block is the first part of the digital filter chain behind an oversampled 4-bit noise-shaping converter. It lowers the sample rate by eight and suppresses the shaped out-of-band noise. It uses three decimate-by-two sinc sections in series. The first two sections have order four and the last has order six. Each section computes ((1 - z^-2)/(1 - z^-1))^K. It does this with a chain of K accumulators that run at its input rate, followed by K differencing stages that run at half that rate. Together the three orders give enough stopband depth against fifth-order shaped noise.

Everything runs on one clock. A sample enters when `in_valid` is high. Inside each section, a phase bit flips on every accepted sample. On every second sample it loads a half-rate pipeline register, and that register feeds the differencing chain. Each accumulator holds its sum in a register in the forward path, so adder glitches do not reach the next stage. All arithmetic is two's complement and wraps. Each section's register width is K + Bin - 1, which gives 7, 11 and 17 bits. A section's result is sign-extended to the next section's input width: 8 bits, then 12 bits. The final 17-bit result leaves on `out_data` with a one-cycle `out_valid` strobe.

Top module: `sinc_cascade_dec8`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 0. Every stored sum and difference starts from zero, so the first outputs after reset use only the samples fed in since reset.
- R2: One `out_valid` pulse is produced for every 8 accepted input samples. The number of pulses never exceeds the number of accepted samples divided by 8.
- R3: Input sample i (0-based, counted from reset, read as a signed 4-bit value) feeds the first section. For every section with order K, output m equals the sum over k = 0..K of C(K,k)·x(2m-(K-1)-k). Terms with a negative index are zero. The result is wrapped to K+Bin-1 bits and sign-extended to the next input width. The stage orders are 4, 4 and 6.
- R4: A constant input x in the range -4..3 settles to x·2^14 on `out_data`. This includes -4, which gives -65536, the most negative 17-bit value.
- R5: The four-bit inputs -8 and 7 wrap modulo the section widths exactly as the R3 formula gives. No saturation is applied.
- R6: Cycles with `in_valid` low have no effect. The output sequence depends only on the order of the accepted samples, not on the gaps between them.
- R7: `out_valid` is never high on two consecutive cycles.
- R8: `out_data` changes only on a cycle where `out_valid` is high, and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all sections |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies one modulator sample |
| in_data | input | 4 | Signed modulator sample |
| out_valid | output | 1 | One-cycle strobe per decimated result |
| out_data | output | 17 | Signed result at one eighth of the input rate |

## Verification
A wrong accumulator or difference register does not stay hidden. Because the differencing chain only cancels the accumulator growth exactly, any error shows up as a lasting offset or ramp in every later `out_data` value, starting at the next output strobe after the fault reaches the last section. A wrong phase bit, or a pipeline load on the wrong sample, moves the strobe or mixes samples from the wrong phase, and this changes the very first result after reset. For that reason the checks compare every output against the binomial formula from reset onward. The bench also counts the strobes, so a lost or extra decimation event is caught within one group of eight inputs.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
    localparam int DEC_M = 2;

    // register width of one section: K*log2(M) + Bin - 1
    function automatic int sect_width(input int order_k, input int bin);
        return order_k * $clog2(DEC_M) + bin - 1;
    endfunction
endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
    parameter int K = 4,
    parameter int B = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [B-1:0] x_i,
    output logic [B-1:0] last_o
);
    typedef struct packed {
        logic [K-1:0][B-1:0] acc;
    } ist_t;

    ist_t st_d, st_q;

    // retimed accumulators: each stage adds the registered sum of the previous one
    always_comb begin
        st_d = st_q;
        if (v_i) begin
            st_d.acc[0] = st_q.acc[0] + x_i;
            for (int j = 1; j < K; j++) begin
                st_d.acc[j] = st_q.acc[j] + st_q.acc[j-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_o = st_q.acc[K-1];
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
    parameter int K = 4,
    parameter int B = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [B-1:0] x_i,
    output logic         v_o,
    output logic [B-1:0] y_o
);
    typedef struct packed {
        logic [K-1:0][B-1:0] y;
        logic [K-1:0][B-1:0] z;
        logic [K-1:0]        v;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        logic [B-1:0] din;
        logic         dv;
        st_d = st_q;
        for (int j = 0; j < K; j++) begin
            din = (j == 0) ? x_i : st_q.y[j-1];
            dv  = (j == 0) ? v_i : st_q.v[j-1];
            st_d.v[j] = dv;
            if (dv) begin
                st_d.y[j] = din - st_q.z[j];
                st_d.z[j] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o = st_q.v[K-1];
    assign y_o = st_q.y[K-1];
endmodule

// File: rtl/sinc_dec2_sect.sv
module sinc_dec2_sect #(
    parameter int K    = 4,
    parameter int BIN  = 4,
    parameter int BOUT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            v_i,
    input  logic [BIN-1:0]  x_i,
    output logic            v_o,
    output logic [BOUT-1:0] y_o
);
    localparam int B = sinc_pkg::sect_width(K, BIN);

    typedef struct packed {
        logic         ph;
        logic         pipe_v;
        logic [B-1:0] pipe;
    } sst_t;

    sst_t st_d, st_q;

    logic [B-1:0] x_ext;
    logic [B-1:0] integ_last;
    logic         comb_v;
    logic [B-1:0] comb_y;

    assign x_ext = B'($signed(x_i));

    sinc_integ_chain #(.K(K), .B(B)) integ_i (
        .clk(clk), .rst_n(rst_n), .v_i(v_i), .x_i(x_ext), .last_o(integ_last)
    );

    // half-rate enable and pipeline register between accumulators and differences
    always_comb begin
        st_d        = st_q;
        st_d.pipe_v = v_i && st_q.ph;
        if (v_i) st_d.ph = ~st_q.ph;
        if (v_i && st_q.ph) st_d.pipe = integ_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sinc_comb_chain #(.K(K), .B(B)) comb_i (
        .clk(clk), .rst_n(rst_n), .v_i(st_q.pipe_v), .x_i(st_q.pipe),
        .v_o(comb_v), .y_o(comb_y)
    );

    assign v_o = comb_v;

    generate
        if (BOUT >= B) begin : g_extend
            assign y_o = BOUT'($signed(comb_y));
        end else begin : g_trunc
            assign y_o = comb_y[B-1 -: BOUT];
        end
    endgenerate
endmodule

// File: rtl/sinc_cascade_dec8.sv
module sinc_cascade_dec8 #(
    parameter int W_IN = 4,
    parameter int W_S2 = 8,
    parameter int W_S3 = 12,
    parameter int K_S1 = 4,
    parameter int K_S2 = 4,
    parameter int K_S3 = 6,
    localparam int OUT_W = sinc_pkg::sect_width(K_S3, W_S3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W_IN-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    logic            v12, v23;
    logic [W_S2-1:0] d12;
    logic [W_S3-1:0] d23;

    sinc_dec2_sect #(.K(K_S1), .BIN(W_IN), .BOUT(W_S2)) sect1_i (
        .clk(clk), .rst_n(rst_n), .v_i(in_valid), .x_i(in_data), .v_o(v12), .y_o(d12)
    );

    sinc_dec2_sect #(.K(K_S2), .BIN(W_S2), .BOUT(W_S3)) sect2_i (
        .clk(clk), .rst_n(rst_n), .v_i(v12), .x_i(d12), .v_o(v23), .y_o(d23)
    );

    sinc_dec2_sect #(.K(K_S3), .BIN(W_S3), .BOUT(OUT_W)) sect3_i (
        .clk(clk), .rst_n(rst_n), .v_i(v23), .x_i(d23), .v_o(out_valid), .y_o(out_data)
    );
endmodule

// File: rtl/sinc_cascade_dec8_chk.sv
module sinc_cascade_dec8_chk #(
    parameter int OW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [OW-1:0] out_data
);
    logic [31:0] in_cnt_q, out_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
        end else begin
            if (in_valid)  in_cnt_q  <= in_cnt_q + 32'd1;
            if (out_valid) out_cnt_q <= out_cnt_q + 32'd1;
        end
    end

    // R1: strobe is never unknown out of reset
    p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_valid));

    // R2: each strobe is backed by eight earlier accepted samples
    p_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_cnt_q + 32'd1) << 3) <= in_cnt_q));

    // R7: strobes are single cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: data holds between strobes
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind sinc_cascade_dec8 sinc_cascade_dec8_chk #(.OW(OUT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sinc_cascade_dec8_tb_top.sv
module sinc_cascade_dec8_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_data = '0;
    logic        out_valid;
    logic [16:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    longint mdl [0:3][0:1023];
    longint got [0:1023];
    int     n_in = 0;
    int     n_got = 0;

    always #10 clk = ~clk;

    sinc_cascade_dec8 dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && n_got < 1024) begin
            got[n_got] = longint'($signed(out_data));
            n_got++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint wrapb(longint v, int b);
        longint m;
        m = v & ((longint'(1) << b) - 1);
        if (m[b-1]) m = m - (longint'(1) << b);
        return m;
    endfunction

    // binomial reference of R3, applied to the three sections in turn
    task automatic run_model();
        int kk [1:3] = '{4, 4, 6};
        int bb [1:3] = '{7, 11, 17};
        int cnt = n_in;
        for (int s = 1; s <= 3; s++) begin
            for (int m = 0; m < cnt / 2; m++) begin
                longint acc = 0;
                longint c = 1;
                for (int k = 0; k <= kk[s]; k++) begin
                    int idx = 2 * m - (kk[s] - 1) - k;
                    if (idx >= 0) acc += c * mdl[s-1][idx];
                    c = c * (kk[s] - k) / (k + 1);
                end
                mdl[s][m] = wrapb(acc, bb[s]);
            end
            cnt = cnt / 2;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", longint'(out_valid), 0);
        chk("R1 reset data", longint'(out_data), 0);
        rst_n = 1'b1;
        n_in = 0;
        n_got = 0;
        @(negedge clk);
        chk("R1 post-reset valid", longint'(out_valid), 0);
    endtask

    task automatic put(int x, int gap);
        in_valid = 1'b1;
        in_data = 4'(x);
        mdl[0][n_in] = wrapb(longint'(x), 4);
        n_in++;
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 4'($urandom);
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_test(string req);
        repeat (120) @(negedge clk);
        run_model();
        chk({req, " R2 strobe count"}, longint'(n_got), longint'(n_in / 8));
        for (int m = 0; m < n_got && m < n_in / 8; m++) begin
            chk({req, " R3 sample"}, got[m], mdl[3][m]);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);

        // impulse: binomial response of whole cascade (R3)
        do_reset();
        put(1, 0);
        for (int i = 1; i < 64; i++) put(0, 0);
        finish_test("R3 impulse");

        // DC at the negative edge of the non-wrapping range (R4)
        do_reset();
        for (int i = 0; i < 256; i++) put(-4, 0);
        finish_test("R4 dc -4");
        chk("R4 dc -4 settled", got[n_got-1], -65536);

        do_reset();
        for (int i = 0; i < 256; i++) put(3, 0);
        finish_test("R4 dc 3");
        chk("R4 dc 3 settled", got[n_got-1], 49152);

        // full-scale random samples wrap (R5)
        do_reset();
        for (int i = 0; i < 512; i++) begin
            int r = int'($urandom_range(0, 3));
            put((r == 0) ? -8 : (r == 1) ? 7 : int'($urandom_range(0, 15)) - 8, 0);
        end
        finish_test("R5 full scale");

        // random idle gaps must not matter (R6)
        do_reset();
        for (int i = 0; i < 512; i++) begin
            put(int'($urandom_range(0, 15)) - 8, int'($urandom_range(0, 3)));
        end
        finish_test("R6 gaps");

        // mid-stream reset restarts from zero history (R1)
        for (int i = 0; i < 13; i++) put(7, 0);
        do_reset();
        for (int i = 0; i < 64; i++) put(int'($urandom_range(0, 7)) - 4, 1);
        finish_test("R1 restart");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule